// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a virtual address after a TLB miss by walking a two-level translation table held in memory. A requester hands it a virtual address together with the kind of access (read or write) and the privilege level (user or supervisor). The walker reads the first-level entry from a table whose base is given on a plain input. It checks that entry, then reads the second-level entry from the 4 KB-aligned table that the first entry points to. It returns either the translated physical address and the final entry for a TLB fill, or a fault report that states the cause.

While walking, the walker keeps the bookkeeping bits of both entries up to date. If the accessed bit of an entry is clear, it writes that entry back with the bit set. On a write access, it also sets the dirty bit of the second-level entry. A write-back is issued only when it changes at least one bit.

The request, memory and result sides are all valid/ready channels.

- **Request channel:** one walk is in flight at a time, and `req_ready` is high only while the walker is idle.
- **Memory request channel:** the walker holds address, write flag and data steady until `mem_req_ready` is seen. A write is complete once it is accepted. A read is answered by one `mem_rsp_valid` pulse in a later cycle. The walker always takes the response, so that channel has no ready.
- **Result channel:** the result is held unchanged until `res_ready` is seen.

Top module: `pgwalk_top`

## Requirements
- R1: `req_ready` is high only when no walk is in progress and no result is pending. A request is taken on a cycle with `req_valid` and `req_ready` both high, and `req_ready` is low from the next cycle until the result is consumed.
- R2: The first memory access of a walk is a read of the first-level entry at `dir_base + 4*VA[31:22]`, with `mem_req_we` low.
- R3: The second-level entry is read at `{PDE[31:12], 12'h000} + 4*VA[21:12]`.
- R4: An entry with bit 0 (present) clear, at either level, ends the walk at once with `res_fault`=1 and `res_prot`=0. No further memory access is made.
- R5: A present entry at either level whose bit 1 (writable) is clear on a write access, or whose bit 2 (user) is clear on a user access, ends the walk with `res_fault`=1 and `res_prot`=1. No further memory access is made.
- R6: Every result carries the request's virtual address on `res_va`, its write flag on `res_write` and its user flag on `res_user`.
- R7: When a passing first-level entry has bit 5 (accessed) clear, the walker writes it back to the same address with bit 5 set and all other bits unchanged. It does this before the second-level read. When bit 5 is already set, no write is made.
- R8: A passing second-level entry is updated with bit 5 set, and with bit 6 (dirty) set when the access is a write. The update is written back to its address only if it differs from the entry that was read.
- R9: A successful walk gives `res_fault`=0, `res_prot`=0, `res_pa` = `{PTE[31:12], VA[11:0]}` and `res_pte` = the updated second-level entry.
- R10: While `mem_req_valid` is high and `mem_req_ready` is low, `mem_req_valid`, `mem_req_addr`, `mem_req_we` and `mem_req_wdata` stay unchanged.
- R11: While `res_valid` is high and `res_ready` is low, every result output stays unchanged. After the result is accepted, the walker is idle again.
- R12: During and right after reset, `req_ready` is high and both `mem_req_valid` and `res_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dir_base | input | 32 | Byte address of the first-level table |
| req_valid | input | 1 | Walk request valid |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_va | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| req_user | input | 1 | 1 for user mode, 0 for supervisor |
| mem_req_valid | output | 1 | Memory access valid |
| mem_req_ready | input | 1 | Memory access accepted |
| mem_req_addr | output | 32 | Entry byte address |
| mem_req_we | output | 1 | 1 for an entry write-back |
| mem_req_wdata | output | 32 | Write-back data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Result accepted |
| res_fault | output | 1 | Walk ended in a fault |
| res_prot | output | 1 | Fault cause: 1 protection, 0 not present |
| res_va | output | 32 | Virtual address of the walk |
| res_write | output | 1 | Access was a write |
| res_user | output | 1 | Access was from user mode |
| res_pa | output | 32 | Physical address on success |
| res_pte | output | 32 | Updated second-level entry for the TLB fill |

## Verification
The hardest situations to reach are the ones where the memory stalls a write-back, or the requester stalls a result, in the same walk where an update is either needed or skipped. Each case depends on particular bit patterns in both entries and on the access type.

The bench covers these by sweeping every combination of present, writable, user and accessed in the first-level entry, the same bits plus dirty in the second-level entry, and every pairing of read/write with user/supervisor. During the sweep, `mem_req_ready` is withheld on pseudo-random cycles and `res_ready` is withheld at random.

For each walk, the bench records every memory access in order and compares it with a sequence it derives from the entry bits. This catches missing, extra and misdirected reads and write-backs.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;
  // entry bit positions used by the checks
  localparam int unsigned BIT_PRESENT = 0;
  localparam int unsigned BIT_WRITE   = 1;
  localparam int unsigned BIT_USER    = 2;
  localparam int unsigned BIT_ACCESS  = 5;
  localparam int unsigned BIT_DIRTY   = 6;
  // bytes per entry, as a shift
  localparam int unsigned ENTRY_SHIFT = 2;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DIR_RD,
    ST_DIR_WAIT,
    ST_DIR_CHK,
    ST_DIR_WB,
    ST_TBL_RD,
    ST_TBL_WAIT,
    ST_TBL_CHK,
    ST_TBL_WB,
    ST_DONE,
    ST_FAULT
  } walk_st_t;
endpackage

// File: rtl/pgwalk_addr.sv
module pgwalk_addr #(
  parameter int unsigned VA_W  = 32,
  parameter int unsigned OFF_W = 12,
  parameter int unsigned IX_W  = 10
) (
  input  logic [VA_W-1:0] dir_base,
  input  logic [VA_W-1:0] new_va,
  input  logic [VA_W-1:0] cur_va,
  input  logic [VA_W-1:0] dir_entry,
  input  logic [VA_W-1:0] leaf_entry,
  output logic [VA_W-1:0] dir_addr,
  output logic [VA_W-1:0] tbl_addr,
  output logic [VA_W-1:0] phys_addr
);
  import pgwalk_pkg::*;

  localparam int unsigned PAD_W  = VA_W - IX_W - ENTRY_SHIFT;
  localparam int unsigned HI_LSB = OFF_W + IX_W;
  localparam int unsigned FR_W   = VA_W - OFF_W;

  logic [IX_W-1:0] hi_ix;
  logic [IX_W-1:0] lo_ix;
  logic [FR_W-1:0] tbl_frame;
  logic [FR_W-1:0] page_frame;

  always_comb begin
    hi_ix      = new_va[HI_LSB +: IX_W];
    lo_ix      = cur_va[OFF_W +: IX_W];
    tbl_frame  = dir_entry[VA_W-1:OFF_W];
    page_frame = leaf_entry[VA_W-1:OFF_W];
    dir_addr   = dir_base + {{PAD_W{1'b0}}, hi_ix, {ENTRY_SHIFT{1'b0}}};
    tbl_addr   = {tbl_frame, {OFF_W{1'b0}}} + {{PAD_W{1'b0}}, lo_ix, {ENTRY_SHIFT{1'b0}}};
    phys_addr  = {page_frame, cur_va[OFF_W-1:0]};
  end
endmodule

// File: rtl/pgwalk_perm.sv
module pgwalk_perm #(
  parameter int unsigned E_W = 32
) (
  input  logic [E_W-1:0] entry,
  input  logic           is_leaf,
  input  logic           acc_write,
  input  logic           acc_user,
  output logic           not_present,
  output logic           prot_viol,
  output logic           need_wb,
  output logic [E_W-1:0] updated
);
  import pgwalk_pkg::*;

  logic [E_W-1:0] set_mask;

  always_comb begin
    not_present = ~entry[BIT_PRESENT];
    prot_viol   = entry[BIT_PRESENT] &
                  ((acc_write & ~entry[BIT_WRITE]) | (acc_user & ~entry[BIT_USER]));
    set_mask              = '0;
    set_mask[BIT_ACCESS]  = 1'b1;
    set_mask[BIT_DIRTY]   = is_leaf & acc_write;
    updated     = entry | set_mask;
    need_wb     = (updated != entry);
  end
endmodule

// File: rtl/pgwalk_fsm.sv
module pgwalk_fsm #(
  parameter int unsigned VA_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [VA_W-1:0] req_va,
  input  logic            req_write,
  input  logic            req_user,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic [VA_W-1:0] mem_req_addr,
  output logic            mem_req_we,
  output logic [VA_W-1:0] mem_req_wdata,
  input  logic            mem_rsp_valid,
  input  logic [VA_W-1:0] mem_rsp_data,
  output logic            res_valid,
  input  logic            res_ready,
  output logic            res_fault,
  output logic            res_prot,
  output logic [VA_W-1:0] va_q,
  output logic            wr_q,
  output logic            usr_q,
  output logic [VA_W-1:0] ent_q,
  output logic [VA_W-1:0] pte_q,
  output logic            leaf,
  input  logic [VA_W-1:0] dir_addr,
  input  logic [VA_W-1:0] tbl_addr,
  input  logic            chk_np,
  input  logic            chk_pv,
  input  logic            chk_wb,
  input  logic [VA_W-1:0] chk_upd
);
  import pgwalk_pkg::*;

  walk_st_t        state;
  logic [VA_W-1:0] addr_q;
  logic [VA_W-1:0] wdata_q;
  logic            prot_q;

  always_comb begin
    req_ready     = (state == ST_IDLE);
    mem_req_valid = (state == ST_DIR_RD) || (state == ST_DIR_WB) ||
                    (state == ST_TBL_RD) || (state == ST_TBL_WB);
    mem_req_we    = (state == ST_DIR_WB) || (state == ST_TBL_WB);
    mem_req_addr  = addr_q;
    mem_req_wdata = wdata_q;
    res_valid     = (state == ST_DONE) || (state == ST_FAULT);
    res_fault     = (state == ST_FAULT);
    res_prot      = (state == ST_FAULT) && prot_q;
    leaf          = (state == ST_TBL_CHK);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      prot_q  <= 1'b0;
      va_q    <= '0;
      wr_q    <= 1'b0;
      usr_q   <= 1'b0;
      ent_q   <= '0;
      pte_q   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            va_q   <= req_va;
            wr_q   <= req_write;
            usr_q  <= req_user;
            addr_q <= dir_addr;
            state  <= ST_DIR_RD;
          end
        end
        ST_DIR_RD: begin
          if (mem_req_ready) state <= ST_DIR_WAIT;
        end
        ST_DIR_WAIT: begin
          if (mem_rsp_valid) begin
            ent_q <= mem_rsp_data;
            state <= ST_DIR_CHK;
          end
        end
        ST_DIR_CHK: begin
          if (chk_np || chk_pv) begin
            prot_q <= chk_pv;
            state  <= ST_FAULT;
          end else if (chk_wb) begin
            wdata_q <= chk_upd;
            state   <= ST_DIR_WB;
          end else begin
            addr_q <= tbl_addr;
            state  <= ST_TBL_RD;
          end
        end
        ST_DIR_WB: begin
          if (mem_req_ready) begin
            addr_q <= tbl_addr;
            state  <= ST_TBL_RD;
          end
        end
        ST_TBL_RD: begin
          if (mem_req_ready) state <= ST_TBL_WAIT;
        end
        ST_TBL_WAIT: begin
          if (mem_rsp_valid) begin
            ent_q <= mem_rsp_data;
            state <= ST_TBL_CHK;
          end
        end
        ST_TBL_CHK: begin
          if (chk_np || chk_pv) begin
            prot_q <= chk_pv;
            state  <= ST_FAULT;
          end else begin
            pte_q   <= chk_upd;
            wdata_q <= chk_upd;
            prot_q  <= 1'b0;
            state   <= chk_wb ? ST_TBL_WB : ST_DONE;
          end
        end
        ST_TBL_WB: begin
          if (mem_req_ready) state <= ST_DONE;
        end
        ST_DONE, ST_FAULT: begin
          if (res_ready) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top #(
  parameter int unsigned VA_W  = 32,
  parameter int unsigned OFF_W = 12,
  parameter int unsigned IX_W  = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [VA_W-1:0] dir_base,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [VA_W-1:0] req_va,
  input  logic            req_write,
  input  logic            req_user,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic [VA_W-1:0] mem_req_addr,
  output logic            mem_req_we,
  output logic [VA_W-1:0] mem_req_wdata,
  input  logic            mem_rsp_valid,
  input  logic [VA_W-1:0] mem_rsp_data,
  output logic            res_valid,
  input  logic            res_ready,
  output logic            res_fault,
  output logic            res_prot,
  output logic [VA_W-1:0] res_va,
  output logic            res_write,
  output logic            res_user,
  output logic [VA_W-1:0] res_pa,
  output logic [VA_W-1:0] res_pte
);
  logic [VA_W-1:0] va_q, ent_q, pte_q;
  logic            wr_q, usr_q, leaf;
  logic [VA_W-1:0] dir_addr, tbl_addr, phys_addr;
  logic            chk_np, chk_pv, chk_wb;
  logic [VA_W-1:0] chk_upd;

  pgwalk_addr #(.VA_W(VA_W), .OFF_W(OFF_W), .IX_W(IX_W)) u_addr (
    .dir_base   (dir_base),
    .new_va     (req_va),
    .cur_va     (va_q),
    .dir_entry  (ent_q),
    .leaf_entry (pte_q),
    .dir_addr   (dir_addr),
    .tbl_addr   (tbl_addr),
    .phys_addr  (phys_addr)
  );

  pgwalk_perm #(.E_W(VA_W)) u_perm (
    .entry       (ent_q),
    .is_leaf     (leaf),
    .acc_write   (wr_q),
    .acc_user    (usr_q),
    .not_present (chk_np),
    .prot_viol   (chk_pv),
    .need_wb     (chk_wb),
    .updated     (chk_upd)
  );

  pgwalk_fsm #(.VA_W(VA_W)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_va        (req_va),
    .req_write     (req_write),
    .req_user      (req_user),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_req_we    (mem_req_we),
    .mem_req_wdata (mem_req_wdata),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .res_valid     (res_valid),
    .res_ready     (res_ready),
    .res_fault     (res_fault),
    .res_prot      (res_prot),
    .va_q          (va_q),
    .wr_q          (wr_q),
    .usr_q         (usr_q),
    .ent_q         (ent_q),
    .pte_q         (pte_q),
    .leaf          (leaf),
    .dir_addr      (dir_addr),
    .tbl_addr      (tbl_addr),
    .chk_np        (chk_np),
    .chk_pv        (chk_pv),
    .chk_wb        (chk_wb),
    .chk_upd       (chk_upd)
  );

  assign res_va    = va_q;
  assign res_write = wr_q;
  assign res_user  = usr_q;
  assign res_pa    = phys_addr;
  assign res_pte   = pte_q;
endmodule

// File: rtl/pgwalk_chk.sv
module pgwalk_chk #(
  parameter int unsigned VA_W  = 32,
  parameter int unsigned OFF_W = 12,
  parameter int unsigned IX_W  = 10
) (
  input logic            clk,
  input logic            rst_n,
  input logic [VA_W-1:0] dir_base,
  input logic            req_valid,
  input logic            req_ready,
  input logic [VA_W-1:0] req_va,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic [VA_W-1:0] mem_req_addr,
  input logic            mem_req_we,
  input logic [VA_W-1:0] mem_req_wdata,
  input logic            res_valid,
  input logic            res_ready,
  input logic            res_fault,
  input logic            res_prot,
  input logic [VA_W-1:0] res_va,
  input logic            res_write,
  input logic [VA_W-1:0] res_pa,
  input logic [VA_W-1:0] res_pte
);
  localparam int unsigned PAD_W = VA_W - IX_W - 2;

  logic [VA_W-1:0] dir_exp;
  assign dir_exp = dir_base + {{PAD_W{1'b0}}, req_va[VA_W-1 -: IX_W], 2'b00};

  p_busy_no_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !req_ready);

  p_first_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && req_valid && req_ready) |->
      (mem_req_valid && !mem_req_we && mem_req_addr == $past(dir_exp)));

  p_mem_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we) &&
       $stable(mem_req_wdata)));

  p_res_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=>
      (res_valid && $stable(res_fault) && $stable(res_prot) &&
       $stable(res_pa) && $stable(res_pte) && $stable(res_va)));

  p_wb_accessed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_we) |-> (mem_req_wdata[5] && mem_req_wdata[0]));

  p_ok_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_fault) |->
      (res_pte[0] && res_pte[5] && !res_prot &&
       res_pa[OFF_W-1:0] == res_va[OFF_W-1:0]));

  p_dirty_on_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_fault && res_write) |-> res_pte[6]);
endmodule

bind pgwalk_top pgwalk_chk #(.VA_W(VA_W), .OFF_W(OFF_W), .IX_W(IX_W)) i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .dir_base      (dir_base),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_va        (req_va),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .mem_req_we    (mem_req_we),
  .mem_req_wdata (mem_req_wdata),
  .res_valid     (res_valid),
  .res_ready     (res_ready),
  .res_fault     (res_fault),
  .res_prot      (res_prot),
  .res_va        (res_va),
  .res_write     (res_write),
  .res_pa        (res_pa),
  .res_pte       (res_pte)
);

// File: tb/test_pgwalk_top.sv
module test_pgwalk_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] dir_base = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_va = '0;
  logic        req_write = 1'b0;
  logic        req_user = 1'b0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_req_we;
  logic [31:0] mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        res_valid;
  logic        res_ready = 1'b0;
  logic        res_fault, res_prot, res_write, res_user;
  logic [31:0] res_va, res_pa, res_pte;

  always #5 clk = ~clk;

  pgwalk_top i_pgwalk_top (
    .clk(clk), .rst_n(rst_n), .dir_base(dir_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
    .req_write(req_write), .req_user(req_user),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_req_we(mem_req_we),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .res_valid(res_valid), .res_ready(res_ready),
    .res_fault(res_fault), .res_prot(res_prot), .res_va(res_va),
    .res_write(res_write), .res_user(res_user), .res_pa(res_pa), .res_pte(res_pte)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // memory model state for the current walk
  logic [31:0] m_pde_a, m_pte_a, m_pde_v, m_pte_v;
  logic [31:0] log_addr [8];
  logic        log_we   [8];
  logic [31:0] log_wd   [8];
  int          log_n = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit          rsp_due = 1'b0;
  logic [31:0] rsp_q = '0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory responder: stalls requests pseudo-randomly, answers reads one cycle later
  initial begin
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (rsp_due) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = rsp_q;
        rsp_due       = 1'b0;
      end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      mem_req_ready = lfsr[0] | lfsr[3];
      if (rst_n && mem_req_valid && mem_req_ready) begin
        if (log_n < 8) begin
          log_addr[log_n] = mem_req_addr;
          log_we[log_n]   = mem_req_we;
          log_wd[log_n]   = mem_req_wdata;
        end
        log_n++;
        if (!mem_req_we) begin
          rsp_due = 1'b1;
          if (mem_req_addr == m_pde_a)      rsp_q = m_pde_v;
          else if (mem_req_addr == m_pte_a) rsp_q = m_pte_v;
          else                              rsp_q = 32'hDEAD_BEEF;
        end
      end
    end
  end

  // pdf = {A,US,RW,P}; ptf = {D,A,US,RW,P}
  task automatic walk(input logic [31:0] va, input logic [31:0] base,
                      input logic [3:0] pdf, input logic [4:0] ptf,
                      input bit wr, input bit us);
    logic [19:0] tfr, pfr;
    logic [31:0] e_addr [4];
    logic        e_we   [4];
    logic [31:0] e_wd   [4];
    string       e_tag  [4];
    int          e_n;
    bit          e_fault, e_prot;
    logic [31:0] upd;
    logic [31:0] snap_pa, snap_pte;
    bit          held;
    tfr = {1'b1, va[21:12] ^ 10'h2B5, va[30:22]};
    pfr = va[31:12] ^ 20'h5A5A5;
    m_pde_v = {tfr, 3'b101, 2'b00, 1'b0, pdf[3], 2'b00, pdf[2:0]};
    m_pte_v = {pfr, 3'b010, 1'b1, 1'b0, ptf[4], ptf[3], 2'b00, ptf[2:0]};
    m_pde_a = base + {20'd0, va[31:22], 2'b00};
    m_pte_a = {tfr, 12'h000} + {20'd0, va[21:12], 2'b00};
    e_n = 0; e_fault = 1'b0; e_prot = 1'b0; upd = '0;
    e_addr[e_n] = m_pde_a; e_we[e_n] = 1'b0; e_wd[e_n] = '0; e_tag[e_n] = "R2"; e_n++;
    if (!pdf[0]) begin
      e_fault = 1'b1;
    end else if ((wr && !pdf[1]) || (us && !pdf[2])) begin
      e_fault = 1'b1; e_prot = 1'b1;
    end else begin
      if (!pdf[3]) begin
        e_addr[e_n] = m_pde_a; e_we[e_n] = 1'b1; e_wd[e_n] = m_pde_v | 32'h20;
        e_tag[e_n] = "R7"; e_n++;
      end
      e_addr[e_n] = m_pte_a; e_we[e_n] = 1'b0; e_wd[e_n] = '0; e_tag[e_n] = "R3"; e_n++;
      if (!ptf[0]) begin
        e_fault = 1'b1;
      end else if ((wr && !ptf[1]) || (us && !ptf[2])) begin
        e_fault = 1'b1; e_prot = 1'b1;
      end else begin
        upd = m_pte_v | 32'h20 | (wr ? 32'h40 : 32'h0);
        if (upd != m_pte_v) begin
          e_addr[e_n] = m_pte_a; e_we[e_n] = 1'b1; e_wd[e_n] = upd;
          e_tag[e_n] = "R8"; e_n++;
        end
      end
    end

    @(negedge clk);
    log_n = 0;
    dir_base = base; req_va = va; req_write = wr; req_user = us; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R1 busy after accept", {31'd0, req_ready}, 32'd0);

    held = 1'b0; snap_pa = '0; snap_pte = '0;
    forever begin
      if (res_valid) begin
        if (held) begin
          chk("R11 held pa", res_pa, snap_pa);
          chk("R11 held pte", res_pte, snap_pte);
        end
        snap_pa = res_pa; snap_pte = res_pte; held = 1'b1;
        if ($urandom_range(0, 2) != 0) begin
          chk(e_prot ? "R5 fault" : "R4 fault", {31'd0, res_fault}, {31'd0, e_fault});
          chk(e_prot ? "R5 cause" : "R4 cause", {31'd0, res_prot}, {31'd0, e_prot});
          chk("R6 va", res_va, va);
          chk("R6 flags", {30'd0, res_write, res_user}, {30'd0, wr, us});
          if (!e_fault) begin
            chk("R9 pa", res_pa, {m_pte_v[31:12], va[11:0]});
            chk("R9 pte", res_pte, upd);
          end
          res_ready = 1'b1;
          @(negedge clk);
          res_ready = 1'b0;
          chk("R11 idle after result", {30'd0, res_valid, req_ready}, 32'd1);
          break;
        end
      end
      @(negedge clk);
    end

    chk(e_fault ? "R4 R5 access count" : "R8 access count", log_n, e_n);
    for (int k = 0; k < e_n && k < log_n && k < 8; k++) begin
      chk({e_tag[k], " addr"}, log_addr[k], e_addr[k]);
      chk({e_tag[k], " we"}, {31'd0, log_we[k]}, {31'd0, e_we[k]});
      if (e_we[k]) chk({e_tag[k], " data"}, log_wd[k], e_wd[k]);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R12 reset ready", {31'd0, req_ready}, 32'd1);
    chk("R12 reset mem", {31'd0, mem_req_valid}, 32'd0);
    chk("R12 reset res", {31'd0, res_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 after reset", {29'd0, req_ready, mem_req_valid, res_valid}, 32'd4);
    for (int n = 0; n < 2048; n++) begin
      logic [31:0] va, base;
      va   = 32'h9E37_79B9 * (n + 1) + 32'h0012_3456;
      base = 32'h0040_0000 + {16'd0, n[3:0], 12'h000};
      walk(va, base, n[3:0], n[8:4], n[9], n[10]);
    end
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R11 watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule